// File: doc/BRIEF.md
# Transmit TDM Port Formatter

This block drives one serial time-division-multiplexed transmit port. The port has its own clock and its own frame sync. Both reach the block as plain inputs. A faster core clock samples them and turns each port-clock transition into a one-cycle event. The block keeps a frame position counter that advances once per active port edge. It re-phases that counter whenever a sync pulse arrives. It splits the frame into eight-bit time slots and shifts each slot's byte out MSB first on the serial data output.

The frame layout follows a two-bit rate field. The sync can be taken up to two port clocks early, or half a clock early. In the half-clock case it is sampled on the opposite port edge. Per-port controls set the polarity of the clock, the sync and the data. An active-low control holds the line at mark. In unchannelized operation the block ignores the sync and the rate, and streams bytes back to back from one of two sources.

The block asks for each slot's byte one slot ahead. It raises a one-cycle request strobe with the number of the slot it wants next. It then latches the byte and that slot's enable at the active edge that starts the slot. If a sync arrives away from the expected frame boundary, the counters follow it at once and a sticky flag is set.

Top module: `tdm_tx_formatter`

## Requirements
- R1: `cfg_mode` sets the frame: 00 gives 193 port clocks and slots 0..23, 01 gives 256 clocks and slots 0..31, 10 gives 512 clocks and slots 0..63, 11 gives 1024 clocks and slots 0..127. Without further syncs the position wraps at the frame end, and `cur_slot` reports the slot of the bit on the line.
- R2: In mode 00 the first position of the frame is a framing bit. It is sent as mark (1 before data polarity) and reports slot 0. Slot 0 data begins at the next position.
- R3: `cfg_adv` places the frame start relative to a sync. 00 makes the active edge that samples the sync position 0. 10 puts position 0 one active edge later, and 11 puts it two active edges later. 01 samples the sync on the opposite port edge and makes the following active edge position 0.
- R4: `cfg_inv_clk`=1 makes the falling port-clock edge the active edge instead of the rising one. `cfg_inv_sync`=1 makes a low level on `port_sync` the sync.
- R5: `cfg_inv_data`=1 inverts every bit driven on `tx_data`.
- R6: While `cfg_pass_n`=0, `tx_data` is 1 after every active edge, regardless of data polarity. With 1, data passes.
- R7: At the active edge that starts slot s, `req` pulses for one core cycle and `req_slot` becomes s+1, wrapping to 0 after the last slot. The byte and enable present at that edge belong to slot s, and its bits go out MSB first, one per active edge.
- R8: A slot whose `slot_en` was 0 when it was latched sends eight ones before data polarity.
- R9: The first sync after reset aligns the counters silently. A later sync that lands away from the expected frame start realigns them at that edge and sets `slip`, which stays set until reset.
- R10: With `cfg_unchan`=1, syncs, `cfg_mode`, `cfg_adv` and `slot_en` have no effect. Bytes follow back to back, each starting eight active edges after the previous one, and `cur_slot` and `req_slot` stay 0.
- R11: With `cfg_unchan`=1, `cfg_src_sel`=0 sends `pkt_byte` and 1 sends `pat_byte`. With `cfg_unchan`=0, `cfg_src_sel` is ignored and `pkt_byte` is sent.
- R12: After reset `tx_data` is 1 and `req`, `slip`, `cur_slot` and `req_slot` are 0. The first active edge with no sync is position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that samples the port signals |
| rst | input | 1 | Synchronous active-high reset |
| port_clk | input | 1 | External port clock, slower than `clk` |
| port_sync | input | 1 | External frame sync |
| cfg_mode | input | 2 | Frame rate select |
| cfg_adv | input | 2 | Sync advance select |
| cfg_inv_clk | input | 1 | Active edge is falling when 1 |
| cfg_inv_sync | input | 1 | Sync active low when 1 |
| cfg_inv_data | input | 1 | Invert serial data when 1 |
| cfg_pass_n | input | 1 | 0 holds output at mark |
| cfg_unchan | input | 1 | Unchannelized operation when 1 |
| cfg_src_sel | input | 1 | Unchannelized source: 0 packet, 1 pattern |
| pkt_byte | input | 8 | Byte from the packet controller |
| pat_byte | input | 8 | Byte from the pattern generator |
| slot_en | input | 1 | Enable for the requested slot |
| tx_data | output | 1 | Serial transmit data |
| cur_slot | output | 7 | Slot of the bit on the line |
| req | output | 1 | One-cycle byte request strobe |
| req_slot | output | 7 | Slot whose byte is wanted next |
| slip | output | 1 | Sticky frame misalignment flag |

## Verification
The bench aligns every rate and then follows whole frames bit by bit. A counter that wrapped one position early or late would fail the check of the sync on the next frame boundary, and a T1 frame that lost its framing bit would shift every slot by one position. Each sync advance gets its own test. An off-by-one in the early settings, or a half-clock setting that sampled on the active edge, would put slot 0's MSB at the wrong edge. The bench also sends a sync in mid-frame to check the sticky slip flag, and checks that the first sync after reset raises no flag. In unchannelized operation it sends a sync and disables the slot: a design that still honoured either would break the byte stream or send ones.

// File: rtl/tdmtx_pkg.sv
package tdmtx_pkg;

    localparam int POS_W  = 10;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int SLOT_W = POS_W - BIT_W;

    typedef enum logic [1:0] {
        RATE_T1   = 2'b00,
        RATE_E1   = 2'b01,
        RATE_S64  = 2'b10,
        RATE_S128 = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        ADV_NONE = 2'b00,
        ADV_HALF = 2'b01,
        ADV_ONE  = 2'b10,
        ADV_TWO  = 2'b11
    } adv_e;

    typedef struct packed {
        logic              framing;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } pos_dec_t;

    function automatic logic [POS_W-1:0] frame_last(input rate_e m, input logic unch);
        logic [POS_W-1:0] r;
        if (unch) begin
            r = POS_W'(BYTE_W - 1);
        end else begin
            unique case (m)
                RATE_T1:  r = POS_W'(192);
                RATE_E1:  r = POS_W'(255);
                RATE_S64: r = POS_W'(511);
                default:  r = POS_W'(1023);
            endcase
        end
        return r;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_last(input rate_e m, input logic unch);
        logic [SLOT_W-1:0] r;
        if (unch) begin
            r = '0;
        end else begin
            unique case (m)
                RATE_T1:  r = SLOT_W'(23);
                RATE_E1:  r = SLOT_W'(31);
                RATE_S64: r = SLOT_W'(63);
                default:  r = SLOT_W'(127);
            endcase
        end
        return r;
    endfunction

    function automatic logic [POS_W-1:0] sync_target(input adv_e a, input logic [POS_W-1:0] last);
        logic [POS_W-1:0] r;
        unique case (a)
            ADV_ONE: r = last;
            ADV_TWO: r = last - 1'b1;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic pos_dec_t decode_pos(input logic [POS_W-1:0] p, input rate_e m,
                                            input logic unch);
        pos_dec_t d;
        logic [POS_W-1:0] q;
        d.framing = 1'b0;
        q = p;
        if (unch) begin
            d.slot = '0;
            d.bitn = p[BIT_W-1:0];
        end else begin
            if (m == RATE_T1) begin
                d.framing = (p == '0);
                q = (p == '0) ? '0 : p - 1'b1;
            end
            d.slot = q[POS_W-1:BIT_W];
            d.bitn = q[BIT_W-1:0];
        end
        return d;
    endfunction

endpackage

// File: rtl/tdmtx_edge.sv
module tdmtx_edge (
    input  logic clk,
    input  logic rst,
    input  logic port_clk,
    input  logic port_sync,
    input  logic inv_clk,
    input  logic inv_sync,
    input  logic half_adv,
    output logic act,
    output logic sync_hit
);
    logic pc, pc_q, opp, sync_lvl, held_q;

    assign pc       = port_clk ^ inv_clk;
    assign sync_lvl = port_sync ^ inv_sync;
    assign act      = pc & ~pc_q;
    assign opp      = ~pc & pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= pc;
            held_q <= 1'b0;
        end else begin
            pc_q <= pc;
            if (opp)      held_q <= sync_lvl;
            else if (act) held_q <= 1'b0;
        end
    end

    assign sync_hit = act & (half_adv ? held_q : sync_lvl);
endmodule

// File: rtl/tdmtx_framer.sv
module tdmtx_framer
    import tdmtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  logic              sync_hit,
    input  rate_e             mode,
    input  adv_e              adv,
    input  logic              unchan,
    output pos_dec_t          dec_nxt,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              slip
);
    logic [POS_W-1:0] pos_q, last, pos_inc, tgt, pos_nxt;
    logic             sync_use, locked_q;

    assign last     = frame_last(mode, unchan);
    assign pos_inc  = (pos_q >= last) ? '0 : pos_q + 1'b1;
    assign tgt      = sync_target(adv, last);
    assign sync_use = sync_hit & ~unchan;
    assign pos_nxt  = sync_use ? tgt : pos_inc;
    assign dec_nxt  = decode_pos(pos_nxt, mode, unchan);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= last;
            cur_slot <= '0;
            locked_q <= 1'b0;
            slip     <= 1'b0;
        end else if (act) begin
            pos_q    <= pos_nxt;
            cur_slot <= dec_nxt.slot;
            if (sync_use) begin
                locked_q <= 1'b1;
                if (locked_q && (pos_inc != tgt)) slip <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdmtx_serializer.sv
module tdmtx_serializer
    import tdmtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  pos_dec_t          dec_nxt,
    input  rate_e             mode,
    input  logic              unchan,
    input  logic              src_sel,
    input  logic [BYTE_W-1:0] pkt_byte,
    input  logic [BYTE_W-1:0] pat_byte,
    input  logic              slot_en,
    input  logic              inv_data,
    input  logic              pass_n,
    output logic              tx_data,
    output logic              req,
    output logic [SLOT_W-1:0] req_slot
);
    logic [BYTE_W-1:0] sh_q, src_byte, new_byte;
    logic [SLOT_W-1:0] last_slot, next_slot;
    logic              slot_start, use_en, raw_bit;

    assign slot_start = ~dec_nxt.framing && (dec_nxt.bitn == '0);
    assign src_byte   = (unchan && src_sel) ? pat_byte : pkt_byte;
    assign use_en     = unchan | slot_en;
    assign new_byte   = use_en ? src_byte : '1;
    assign last_slot  = slot_last(mode, unchan);
    assign next_slot  = (unchan || dec_nxt.slot >= last_slot) ? '0 : dec_nxt.slot + 1'b1;

    always_comb begin
        if (dec_nxt.framing)  raw_bit = 1'b1;
        else if (slot_start)  raw_bit = new_byte[BYTE_W-1];
        else                  raw_bit = sh_q[BIT_W'(BYTE_W-1) - dec_nxt.bitn];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '1;
            tx_data  <= 1'b1;
            req      <= 1'b0;
            req_slot <= '0;
        end else begin
            req <= act & slot_start;
            if (act) begin
                tx_data <= pass_n ? (raw_bit ^ inv_data) : 1'b1;
                if (slot_start) begin
                    sh_q     <= new_byte;
                    req_slot <= next_slot;
                end
            end
        end
    end
endmodule

// File: rtl/tdm_tx_formatter.sv
module tdm_tx_formatter
    import tdmtx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       port_clk,
    input  logic       port_sync,
    input  logic [1:0] cfg_mode,
    input  logic [1:0] cfg_adv,
    input  logic       cfg_inv_clk,
    input  logic       cfg_inv_sync,
    input  logic       cfg_inv_data,
    input  logic       cfg_pass_n,
    input  logic       cfg_unchan,
    input  logic       cfg_src_sel,
    input  logic [7:0] pkt_byte,
    input  logic [7:0] pat_byte,
    input  logic       slot_en,
    output logic       tx_data,
    output logic [6:0] cur_slot,
    output logic       req,
    output logic [6:0] req_slot,
    output logic       slip
);
    rate_e    mode;
    adv_e     adv;
    logic     act_w, sync_hit_w;
    pos_dec_t dec_nxt_w;

    assign mode = rate_e'(cfg_mode);
    assign adv  = adv_e'(cfg_adv);

    tdmtx_edge i_edge (
        .clk      (clk),
        .rst      (rst),
        .port_clk (port_clk),
        .port_sync(port_sync),
        .inv_clk  (cfg_inv_clk),
        .inv_sync (cfg_inv_sync),
        .half_adv (adv == ADV_HALF),
        .act      (act_w),
        .sync_hit (sync_hit_w)
    );

    tdmtx_framer i_framer (
        .clk     (clk),
        .rst     (rst),
        .act     (act_w),
        .sync_hit(sync_hit_w),
        .mode    (mode),
        .adv     (adv),
        .unchan  (cfg_unchan),
        .dec_nxt (dec_nxt_w),
        .cur_slot(cur_slot),
        .slip    (slip)
    );

    tdmtx_serializer i_ser (
        .clk     (clk),
        .rst     (rst),
        .act     (act_w),
        .dec_nxt (dec_nxt_w),
        .mode    (mode),
        .unchan  (cfg_unchan),
        .src_sel (cfg_src_sel),
        .pkt_byte(pkt_byte),
        .pat_byte(pat_byte),
        .slot_en (slot_en),
        .inv_data(cfg_inv_data),
        .pass_n  (cfg_pass_n),
        .tx_data (tx_data),
        .req     (req),
        .req_slot(req_slot)
    );
endmodule

// File: rtl/tdm_tx_formatter_chk.sv
module tdm_tx_formatter_chk
    import tdmtx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       act,
    input logic [1:0] cfg_mode,
    input logic       cfg_pass_n,
    input logic       cfg_unchan,
    input logic       tx_data,
    input logic [6:0] cur_slot,
    input logic       req,
    input logic [6:0] req_slot,
    input logic       slip
);
    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cur_slot <= slot_last(rate_e'(cfg_mode), cfg_unchan));  // R1

    AST_REQ_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        req |-> req_slot <= slot_last(rate_e'(cfg_mode), cfg_unchan));  // R7

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);  // R7

    AST_LINE_HELD_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (rst)
        !$past(act) |-> ($stable(tx_data) && $stable(cur_slot)));  // R7

    AST_FORCED_MARK: assert property (@(posedge clk) disable iff (rst)
        ($past(act) && !$past(cfg_pass_n)) |-> tx_data);  // R6

    AST_SLIP_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(slip) |-> slip);  // R9

    AST_UNCHAN_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_unchan && $past(cfg_unchan) && $past(act)) |-> (cur_slot == '0 && req_slot == '0));  // R10
endmodule

bind tdm_tx_formatter tdm_tx_formatter_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .act       (act_w),
    .cfg_mode  (cfg_mode),
    .cfg_pass_n(cfg_pass_n),
    .cfg_unchan(cfg_unchan),
    .tx_data   (tx_data),
    .cur_slot  (cur_slot),
    .req       (req),
    .req_slot  (req_slot),
    .slip      (slip)
);

// File: tb/test_tdm_tx_formatter.sv
`timescale 1ns/1ps
module test_tdm_tx_formatter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_clk = 1'b0;
    logic       port_sync = 1'b0;
    logic [1:0] mode_c = 2'b01;
    logic [1:0] adv_c = 2'b00;
    logic       inv_clk_c = 1'b0, inv_sync_c = 1'b0, inv_data_c = 1'b0;
    logic       pass_c = 1'b1, unchan_c = 1'b0, src_c = 1'b0;
    logic [7:0] pkt_byte, pat_byte;
    logic       slot_en;
    logic       tx_data, req, slip;
    logic [6:0] cur_slot, req_slot;
    int         dis_slot = -1;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] pkt_fn(input int s);
        return 8'((s * 13) ^ 60);
    endfunction

    assign pkt_byte = pkt_fn(int'(req_slot));
    assign pat_byte = ~pkt_fn(int'(req_slot));
    assign slot_en  = (dis_slot != int'(req_slot));

    tdm_tx_formatter i_tdm_tx_formatter (
        .clk(clk), .rst(rst), .port_clk(port_clk), .port_sync(port_sync),
        .cfg_mode(mode_c), .cfg_adv(adv_c), .cfg_inv_clk(inv_clk_c),
        .cfg_inv_sync(inv_sync_c), .cfg_inv_data(inv_data_c), .cfg_pass_n(pass_c),
        .cfg_unchan(unchan_c), .cfg_src_sel(src_c), .pkt_byte(pkt_byte),
        .pat_byte(pat_byte), .slot_en(slot_en), .tx_data(tx_data),
        .cur_slot(cur_slot), .req(req), .req_slot(req_slot), .slip(slip)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act_v, exp_v);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        port_clk = inv_clk_c;
        port_sync = inv_sync_c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // one port clock: opposite half then active half; returns just after the active edge is processed
    task automatic step(input bit s_opp, input bit s_act);
        port_clk = inv_clk_c;
        port_sync = s_opp ^ inv_sync_c;
        repeat (3) @(negedge clk);
        port_clk = ~inv_clk_c;
        port_sync = s_act ^ inv_sync_c;
        @(negedge clk);
    endtask

    function automatic bit exp_bit(input int p, input bit t1);
        int q;
        logic [7:0] b;
        bit r;
        if (t1 && p == 0) r = 1'b1;
        else begin
            q = t1 ? p - 1 : p;
            b = (dis_slot == q / 8) ? 8'hFF : pkt_fn(q / 8);
            r = b[7 - (q % 8)];
        end
        if (!pass_c) return 1'b1;
        return r ^ inv_data_c;
    endfunction

    function automatic int exp_slot(input int p, input bit t1);
        if (t1) return (p == 0) ? 0 : (p - 1) / 8;
        return p / 8;
    endfunction

    task automatic check_at(input int p, input bit t1, input string rq);
        chk(tx_data == exp_bit(p, t1), rq, $sformatf("tx_data at pos %0d", p),
            int'(tx_data), int'(exp_bit(p, t1)));
        chk(int'(cur_slot) == exp_slot(p, t1), rq, $sformatf("cur_slot at pos %0d", p),
            int'(cur_slot), exp_slot(p, t1));
    endtask

    task automatic run_span(input int p0, input int n, input int len, input bit t1,
                            input string rq);
        for (int k = 0; k < n; k++) begin
            step(1'b0, 1'b0);
            check_at((p0 + k) % len, t1, rq);
        end
    endtask

    task automatic setup(input logic [1:0] m, input logic [1:0] a);
        mode_c = m; adv_c = a;
        inv_clk_c = 0; inv_sync_c = 0; inv_data_c = 0;
        pass_c = 1; unchan_c = 0; src_c = 0; dis_slot = -1;
        do_reset();
    endtask

    task automatic t_reset();
        setup(2'b01, 2'b00);
        chk(tx_data == 1'b1, "R12", "tx_data after reset", int'(tx_data), 1);
        chk(req == 1'b0 && slip == 1'b0, "R12", "req|slip after reset", int'({req, slip}), 0);
        chk(cur_slot == 0 && req_slot == 0, "R12", "slots after reset", int'(cur_slot), 0);
        step(1'b0, 1'b0);
        check_at(0, 1'b0, "R12");
    endtask

    task automatic t_e1();
        setup(2'b01, 2'b00);
        step(1'b0, 1'b1);
        check_at(0, 1'b0, "R3");
        chk(req == 1'b1 && req_slot == 7'd1, "R7", "request at slot 0 start",
            int'(req_slot), 1);
        chk(slip == 1'b0, "R9", "slip after first sync", int'(slip), 0);
        run_span(1, 255, 256, 1'b0, "R7");
        chk(req_slot == 7'd0, "R7", "req_slot wraps in last slot", int'(req_slot), 0);
        step(1'b0, 1'b1);
        check_at(0, 1'b0, "R1");
        chk(slip == 1'b0, "R1", "aligned sync at 256 clocks", int'(slip), 0);
        run_span(1, 20, 256, 1'b0, "R1");
    endtask

    task automatic t_t1();
        setup(2'b00, 2'b00);
        step(1'b0, 1'b1);
        chk(tx_data == 1'b1 && cur_slot == 0, "R2", "framing bit", int'(tx_data), 1);
        run_span(1, 192, 193, 1'b1, "R2");
        step(1'b0, 1'b1);
        check_at(0, 1'b1, "R1");
        chk(slip == 1'b0, "R1", "aligned sync at 193 clocks", int'(slip), 0);
        run_span(1, 16, 193, 1'b1, "R2");
    endtask

    task automatic t_big(input logic [1:0] m, input int len, input string rq);
        setup(m, 2'b00);
        step(1'b0, 1'b1);
        check_at(0, 1'b0, rq);
        run_span(1, len - 1, len, 1'b0, rq);
        step(1'b0, 1'b1);
        chk(slip == 1'b0, rq, $sformatf("aligned sync at %0d clocks", len), int'(slip), 0);
        check_at(0, 1'b0, rq);
    endtask

    task automatic t_adv(input logic [1:0] a, input int early);
        setup(2'b01, a);
        if (a == 2'b01) begin
            step(1'b1, 1'b0);
        end else begin
            step(1'b0, 1'b1);
            for (int k = 0; k < early; k++) begin
                chk(cur_slot == 7'd31, "R3", "slot before frame start", int'(cur_slot), 31);
                step(1'b0, 1'b0);
            end
        end
        check_at(0, 1'b0, "R3");
        run_span(1, 15, 256, 1'b0, "R3");
    endtask

    task automatic t_polarity();
        setup(2'b01, 2'b00);
        inv_clk_c = 1; inv_sync_c = 1;
        do_reset();
        step(1'b0, 1'b1);
        check_at(0, 1'b0, "R4");
        run_span(1, 15, 256, 1'b0, "R4");
        chk(slip == 1'b0, "R4", "no slip with inverted sync idle", int'(slip), 0);
        setup(2'b01, 2'b00);
        inv_data_c = 1;
        step(1'b0, 1'b1);
        check_at(0, 1'b0, "R5");
        run_span(1, 23, 256, 1'b0, "R5");
    endtask

    task automatic t_force();
        setup(2'b01, 2'b00);
        pass_c = 0; inv_data_c = 1;
        step(1'b0, 1'b1);
        for (int k = 1; k < 16; k++) begin
            step(1'b0, 1'b0);
            chk(tx_data == 1'b1, "R6", "forced mark", int'(tx_data), 1);
        end
        pass_c = 1;
        run_span(16, 16, 256, 1'b0, "R6");
    endtask

    task automatic t_disabled();
        setup(2'b01, 2'b00);
        dis_slot = 2;
        step(1'b0, 1'b1);
        check_at(0, 1'b0, "R8");
        run_span(1, 31, 256, 1'b0, "R8");
    endtask

    task automatic t_slip();
        setup(2'b01, 2'b00);
        step(1'b0, 1'b1);
        run_span(1, 100, 256, 1'b0, "R9");
        chk(slip == 1'b0, "R9", "no slip before stray sync", int'(slip), 0);
        step(1'b0, 1'b1);
        chk(slip == 1'b1, "R9", "slip on stray sync", int'(slip), 1);
        chk(cur_slot == 0, "R9", "realigned to slot 0", int'(cur_slot), 0);
        for (int k = 0; k < 7; k++) step(1'b0, 1'b0);
        chk(slip == 1'b1, "R9", "slip sticky", int'(slip), 1);
        chk(cur_slot == 0, "R9", "still slot 0 after 8 clocks", int'(cur_slot), 0);
        step(1'b0, 1'b0);
        chk(cur_slot == 1, "R9", "slot 1 after realign", int'(cur_slot), 1);
    endtask

    task automatic t_unchan(input bit sel);
        logic [7:0] b;
        setup(2'b00, 2'b11);
        unchan_c = 1; src_c = sel; dis_slot = 0;
        do_reset();
        b = sel ? ~pkt_fn(0) : pkt_fn(0);
        for (int k = 0; k < 24; k++) begin
            step(1'b0, (k == 11));
            chk(tx_data == b[7 - (k % 8)], sel ? "R11" : "R10",
                $sformatf("unchannelized bit %0d", k), int'(tx_data), int'(b[7 - (k % 8)]));
            chk(cur_slot == 0 && req_slot == 0, "R10", "slots stay 0", int'(cur_slot), 0);
        end
        chk(slip == 1'b0, "R10", "sync ignored", int'(slip), 0);
    endtask

    task automatic t_src_chan();
        setup(2'b01, 2'b00);
        src_c = 1;
        step(1'b0, 1'b1);
        check_at(0, 1'b0, "R11");
        run_span(1, 15, 256, 1'b0, "R11");
    endtask

    initial begin
        t_reset();
        t_e1();
        t_t1();
        t_big(2'b10, 512, "R1");
        t_big(2'b11, 1024, "R1");
        t_adv(2'b00, 0);
        t_adv(2'b10, 1);
        t_adv(2'b11, 2);
        t_adv(2'b01, 0);
        t_polarity();
        t_force();
        t_disabled();
        t_slip();
        t_unchan(1'b0);
        t_unchan(1'b1);
        t_src_chan();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule